// File: doc/BRIEF.md
# Synchronous Parallel FIFO Port

This block is the device end of an 8-bit parallel byte port that an external host clocks through in bursts. It divides the core clock into a forwarded port clock with an even duty cycle. On each rising edge of that clock it can move one byte from an internal receive queue to the host, or one byte from the host into an internal transmit queue. The host drives three active-low strobes: an output enable, a read strobe and a write strobe. The block returns two active-low flags. The receive-ready flag is low while a byte is waiting. The transmit-space flag is low while a write can still be taken. Both flags are registered and change only at the port clock's rising edge.

The data pins are split at the block edge into an input byte, an output byte and an output-enable. The pad ring builds the bidirectional bus from these three. The block drives the bus only while the host holds the output enable low, so the host must lower that enable before it starts a read burst. The next receive byte is prefetched into the output register, so a read strobe held low yields one byte on every port edge. A small skid buffer on the write side lets the transmit-space flag stop a burst exactly when no room is left. With a 96 MHz core clock and the default divide of 2, the port clock has the nominal 20.83 ns period.

Top module: `sfp_port`

## Requirements
- R1: `port_clk` is the core clock divided by `CLK_DIV` (even, at least 2), high for half of each period. It rises on the core edge where the port state updates, and `rxf_n`, `txe_n` and `d_out` never change at any other core edge.
- R2: While `rst_n` is low, the following hold after each core edge: `rxf_n` = 1, `txe_n` = 1, `port_clk` = 0, `rx_ready` = 0 and `tx_valid` = 0.
- R3: `d_oe` is 1 exactly while `oe_n` is 0. The bus is never driven while the output enable is high.
- R4: A read transfer happens at a port edge only when `rxf_n`, `oe_n` and `rd_n` are all 0. With `oe_n` high, a low `rd_n` consumes nothing.
- R5: `rxf_n` is 0 exactly while an unread byte sits on `d_out`. When a read consumes it and the receive queue has data, the next byte appears on `d_out` at that same edge, with `rxf_n` staying 0 and no idle cycle.
- R6: At the edge that consumes the last available byte, `rxf_n` goes to 1. Holding `rd_n` low afterwards pops nothing. A byte that arrives later is presented, with `rxf_n` = 0, at the next port edge.
- R7: A write transfer happens at a port edge when `txe_n` and `wr_n` are 0 and `rd_n` is 1. One byte is taken from `d_in` per edge, and the bytes are passed to the transmit queue in arrival order.
- R8: `txe_n` goes to 1 at the port edge where the skid buffer reaches `WR_DEPTH` bytes, and writes while it is 1 are dropped. It returns to 0 at the first port edge after room reappears. The buffer never holds more than `WR_DEPTH` bytes.
- R9: When `rd_n` and `wr_n` are both 0 at a port edge, the write is dropped, whether or not a read takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| port_clk | output | 1 | Forwarded port clock |
| oe_n | input | 1 | Host output enable, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| rxf_n | output | 1 | Low while a read byte is available |
| txe_n | output | 1 | Low while a write can be accepted |
| d_in | input | 8 | Byte from the bus pads (write data) |
| d_out | output | 8 | Byte to the bus pads (read data) |
| d_oe | output | 1 | Pad drive enable for `d_out` |
| rx_valid | input | 1 | Receive queue has a byte |
| rx_data | input | 8 | Receive queue head byte |
| rx_ready | output | 1 | Receive queue pop |
| tx_valid | output | 1 | Byte offered to the transmit queue |
| tx_data | output | 8 | Byte offered to the transmit queue |
| tx_ready | input | 1 | Transmit queue accepts the byte |

## Verification
A stale prefetch register shows up as a repeated or skipped byte on `d_out` at the very next port edge after a read. A wrong valid bit shows up as `rxf_n` staying low after the last byte, or as an extra receive pop that the source count exposes. A skid count that drifts shows at the ports as `txe_n` rising one edge late or early, or as a missing or surplus byte at the transmit side once the queue is released. The bench checks that within two port edges. A write that gets through while a read strobe is low surfaces as an extra byte at the transmit queue within one core cycle.

// File: rtl/sfp_pkg.sv
// Package: shared types for the synchronous parallel FIFO port.
// Assumes: strobes from the host are active low and already synchronous
// to the forwarded port clock.
package sfp_pkg;

    // Smallest legal divide of the core clock into the port clock.
    localparam int unsigned SFP_MIN_DIV = 2;

    // Host strobes as sampled by the block.
    typedef struct packed {
        logic oe_n;
        logic rd_n;
        logic wr_n;
    } host_strobe_t;

endpackage

// File: rtl/sfp_clk_div.sv
// Module: sfp_clk_div
// Divides the core clock by DIV into a forwarded port clock with an even
// duty cycle. It also gives a one-cycle 'tick' marking the core edge at
// which the port clock rises. Every port register advances only on that edge.
// Assumes: DIV is even and at least 2.
module sfp_clk_div #(
    parameter int unsigned DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic port_clk,
    output logic tick
);
    localparam int unsigned CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);
    localparam logic [CW-1:0] HALF = CW'(DIV / 2);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nxt;
    logic          clk_q;

    assign tick     = (cnt_q == LAST);
    assign cnt_nxt  = tick ? '0 : cnt_q + 1'b1;
    assign port_clk = clk_q;

    // Phase counter and registered port clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            clk_q <= 1'b0;
        end else begin
            cnt_q <= cnt_nxt;
            clk_q <= (cnt_nxt < HALF);
        end
    end

    AST_RISE_ONLY_AT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_q) |-> $past(tick)); // R1
    AST_HIGH_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> clk_q); // R1

endmodule

// File: rtl/sfp_rd_path.sv
// Module: sfp_rd_path
// Read side. Holds one prefetched byte in an output register. It refills
// the register from the receive queue at the same port edge that a read
// consumes it, and shows the register's valid bit on the receive-ready flag.
// Assumes: 'tick' is high for one core cycle per port clock.
module sfp_rd_path #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         oe_n,
    input  logic         rd_n,
    input  logic         rx_valid,
    input  logic [W-1:0] rx_data,
    output logic         rx_ready,
    output logic         rxf_n,
    output logic [W-1:0] rd_q
);
    logic vld_q;
    logic rd_xfer;
    logic slot_free;
    logic load;

    assign rd_xfer   = tick && vld_q && !oe_n && !rd_n;
    assign slot_free = !vld_q || rd_xfer;
    assign rx_ready  = tick && slot_free;
    assign load      = rx_ready && rx_valid;
    assign rxf_n     = !vld_q;

    // Valid bit of the prefetch register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
        end else if (load) begin
            vld_q <= 1'b1;
        end else if (rd_xfer) begin
            vld_q <= 1'b0;
        end
    end

    // Prefetch data register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (load) begin
            rd_q <= rx_data;
        end
    end

    AST_REFILL_SAME_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_xfer && rx_valid) |=> !rxf_n); // R5
    AST_LAST_BYTE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_xfer && !rx_valid) |=> rxf_n); // R6
    AST_RD_HOLD_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(rxf_n) && $stable(rd_q))); // R1
    AST_NO_READ_WITHOUT_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && oe_n && vld_q) |=> (!rxf_n && $stable(rd_q))); // R4

endmodule

// File: rtl/sfp_wr_path.sv
// Module: sfp_wr_path
// Write side. A DEPTH-entry skid buffer takes host bytes at port edges and
// drains them into the transmit queue on any core cycle. The transmit-space
// flag is recomputed at every port edge from the count that edge leaves, so
// a burst stops exactly when the buffer fills.
// Assumes: DEPTH >= 2; a low read strobe always blocks a write.
module sfp_wr_path #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         rd_n,
    input  logic         wr_n,
    input  logic [W-1:0] wdata,
    input  logic         tx_ready,
    output logic         tx_valid,
    output logic [W-1:0] tx_data,
    output logic         txe_n
);
    localparam int unsigned AW   = $clog2(DEPTH);
    localparam int unsigned CNTW = $clog2(DEPTH + 1);
    localparam logic [CNTW-1:0] FULL = CNTW'(DEPTH);

    logic [W-1:0]    mem_q [DEPTH];
    logic [AW-1:0]   wp_q;
    logic [AW-1:0]   rp_q;
    logic [CNTW-1:0] cnt_q;
    logic [CNTW-1:0] cnt_nxt;
    logic            txe_q;
    logic            push;
    logic            pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign push     = tick && !txe_q && !wr_n && rd_n;
    assign pop      = (cnt_q != '0) && tx_ready;
    assign cnt_nxt  = cnt_q + CNTW'(push) - CNTW'(pop);
    assign tx_valid = (cnt_q != '0);
    assign tx_data  = mem_q[rp_q];
    assign txe_n    = txe_q;

    // Skid storage, written only on an accepted host byte.
    always_ff @(posedge clk) begin
        if (push) begin
            mem_q[wp_q] <= wdata;
        end
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wp_q <= bump(wp_q);
            if (pop)  rp_q <= bump(rp_q);
            cnt_q <= cnt_nxt;
        end
    end

    // Transmit-space flag, updated only at port edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txe_q <= 1'b1;
        end else if (tick) begin
            txe_q <= (cnt_nxt == FULL);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL); // R8
    AST_ROOM_WHEN_TXE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !txe_q |-> (cnt_q < FULL)); // R8
    AST_READ_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !rd_n) |=> (cnt_q <= $past(cnt_q))); // R9
    AST_TXE_HOLD_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(txe_q)); // R1

endmodule

// File: rtl/sfp_port.sv
// Module: sfp_port (top)
// Device side of a clocked 8-bit parallel FIFO port: clock divider, read
// prefetch path and write skid path. The pad ring forms the bidirectional
// bus from d_out / d_oe / d_in.
// Assumes: host strobes meet setup to the rising edge of port_clk.
module sfp_port #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned CLK_DIV  = 2,
    parameter int unsigned WR_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              port_clk,
    input  logic              oe_n,
    input  logic              rd_n,
    input  logic              wr_n,
    output logic              rxf_n,
    output logic              txe_n,
    input  logic [DATA_W-1:0] d_in,
    output logic [DATA_W-1:0] d_out,
    output logic              d_oe,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_ready
);
    import sfp_pkg::*;

    localparam int unsigned DIV_USED = (CLK_DIV < SFP_MIN_DIV) ? SFP_MIN_DIV : CLK_DIV;

    host_strobe_t strb;
    logic         tick;

    assign strb = '{oe_n: oe_n, rd_n: rd_n, wr_n: wr_n};

    // Bus turnaround: drive only while the host enables output.
    assign d_oe = !strb.oe_n;

    sfp_clk_div #(.DIV(DIV_USED)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .port_clk (port_clk),
        .tick     (tick)
    );

    sfp_rd_path #(.W(DATA_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .oe_n     (strb.oe_n),
        .rd_n     (strb.rd_n),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rx_ready (rx_ready),
        .rxf_n    (rxf_n),
        .rd_q     (d_out)
    );

    sfp_wr_path #(.W(DATA_W), .DEPTH(WR_DEPTH)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .rd_n     (strb.rd_n),
        .wr_n     (strb.wr_n),
        .wdata    (d_in),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .txe_n    (txe_n)
    );

    AST_QUIET_IN_RESET: assert property (@(posedge clk)
        !rst_n |=> (rxf_n && txe_n && !port_clk && !rx_ready && !tx_valid)); // R2

endmodule

// File: tb/test_sfp_port.sv
`timescale 1ns/1ps
module test_sfp_port;
    localparam real CLK_P = 5.0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       oe_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0] host_d = 8'h00;
    logic       tx_ready = 1'b1;
    logic       port_clk, rxf_n, txe_n, d_oe, rx_ready, tx_valid, rx_valid;
    logic [7:0] d_out, tx_data, rx_data;

    int n_chk = 0;
    int n_bad = 0;

    // Receive source and transmit sink models.
    logic [7:0] rx_src [8];
    int         rx_idx = 0;
    int         rx_avail = 0;
    logic [7:0] sink [16];
    int         sink_n = 0;

    assign rx_valid = (rx_idx < rx_avail);
    assign rx_data  = rx_src[rx_idx[2:0]];

    always #(CLK_P / 2.0) clk = ~clk;

    always @(posedge clk) begin
        if (rx_valid && rx_ready) rx_idx <= rx_idx + 1;
        if (tx_valid && tx_ready) begin
            sink[sink_n[3:0]] <= tx_data;
            sink_n <= sink_n + 1;
        end
    end

    sfp_port i_sfp_port (
        .clk(clk), .rst_n(rst_n), .port_clk(port_clk),
        .oe_n(oe_n), .rd_n(rd_n), .wr_n(wr_n),
        .rxf_n(rxf_n), .txe_n(txe_n),
        .d_in(host_d), .d_out(d_out), .d_oe(d_oe),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
    );

    // Stimulus/expectation vector: strobes, write byte, expected flags,
    // data check kind (0 none, 1 value driven, 2 not driven), expected byte.
    typedef struct packed {
        logic       oe_n;
        logic       rd_n;
        logic       wr_n;
        logic [7:0] wd;
        logic       xrxf;
        logic       xtxe;
        logic [1:0] dchk;
        logic [7:0] xd;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 2'd2, 8'h00}, // R3 idle, bus released
        '{1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 2'd2, 8'h00}, // R4 rd without oe
        '{1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 2'd1, 8'hA0}, // R3 oe only
        '{1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 2'd1, 8'hA1}, // R5 burst read
        '{1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 2'd1, 8'hA2}, // R5 burst read
        '{1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 2'd0, 8'h00}, // R6 last byte
        '{1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 2'd0, 8'h00}, // R6 held, empty
        '{1'b1, 1'b1, 1'b0, 8'h55, 1'b1, 1'b0, 2'd2, 8'h00}, // R7 write
        '{1'b1, 1'b1, 1'b0, 8'h66, 1'b1, 1'b0, 2'd2, 8'h00}, // R7 write
        '{1'b1, 1'b0, 1'b0, 8'h99, 1'b1, 1'b0, 2'd2, 8'h00}, // R9 both strobes
        '{1'b1, 1'b1, 1'b1, 8'h00, 1'b1, 1'b0, 2'd2, 8'h00}  // R7 idle
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic o, input logic r, input logic w, input logic [7:0] d);
        oe_n = o; rd_n = r; wr_n = w; host_d = d;
    endtask

    task automatic port_edge();
        @(posedge port_clk);
        #1;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000.0);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        real t0, t1, t2;
        rx_src[0] = 8'hA0; rx_src[1] = 8'hA1; rx_src[2] = 8'hA2; rx_src[3] = 8'hC3;
        rx_src[4] = 8'h00; rx_src[5] = 8'h00; rx_src[6] = 8'h00; rx_src[7] = 8'h00;
        rx_avail = 3;
        repeat (4) @(posedge clk);
        #1;
        // R2 reset state
        chk("R2 rxf_n", {7'd0, rxf_n}, 8'd1);
        chk("R2 txe_n", {7'd0, txe_n}, 8'd1);
        chk("R2 port_clk", {7'd0, port_clk}, 8'd0);
        chk("R2 rx_ready", {7'd0, rx_ready}, 8'd0);
        chk("R2 tx_valid", {7'd0, tx_valid}, 8'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 port clock period and high time (DIV 2 -> 10 ns, 5 ns high)
        @(posedge port_clk); t0 = $realtime;
        @(negedge port_clk); t1 = $realtime;
        @(posedge port_clk); t2 = $realtime;
        chk("R1 period ns", 8'($rtoi(t2 - t0 + 0.5)), 8'd10);
        chk("R1 high ns", 8'($rtoi(t1 - t0 + 0.5)), 8'd5);
        #1;

        // Vector table
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].oe_n, VEC[i].rd_n, VEC[i].wr_n, VEC[i].wd);
            port_edge();
            chk($sformatf("R5 vec%0d rxf_n", i), {7'd0, rxf_n}, {7'd0, VEC[i].xrxf});
            chk($sformatf("R8 vec%0d txe_n", i), {7'd0, txe_n}, {7'd0, VEC[i].xtxe});
            if (VEC[i].dchk == 2'd1) begin
                chk($sformatf("R3 vec%0d d_oe", i), {7'd0, d_oe}, 8'd1);
                chk($sformatf("R5 vec%0d d_out", i), d_out, VEC[i].xd);
            end else if (VEC[i].dchk == 2'd2) begin
                chk($sformatf("R3 vec%0d d_oe", i), {7'd0, d_oe}, 8'd0);
            end
        end
        chk("R6 pops", 8'(rx_idx), 8'd3);
        chk("R9 sink count", 8'(sink_n), 8'd2);
        chk("R7 sink0", sink[0], 8'h55);
        chk("R7 sink1", sink[1], 8'h66);

        // R6 late byte raises availability at next edge
        rx_avail = 4;
        drive(1'b0, 1'b1, 1'b1, 8'h00);
        port_edge();
        chk("R6 late rxf_n", {7'd0, rxf_n}, 8'd0);
        chk("R6 late d_out", d_out, 8'hC3);
        // R9 read and write together: read happens, write dropped
        drive(1'b0, 1'b0, 1'b0, 8'hEE);
        port_edge();
        chk("R9 rxf_n after read", {7'd0, rxf_n}, 8'd1);
        chk("R9 pops", 8'(rx_idx), 8'd4);
        chk("R9 sink unchanged", 8'(sink_n), 8'd2);

        // R8 full boundary with a stalled transmit queue
        tx_ready = 1'b0;
        drive(1'b1, 1'b1, 1'b0, 8'h11);
        port_edge();
        chk("R8 one stored txe_n", {7'd0, txe_n}, 8'd0);
        drive(1'b1, 1'b1, 1'b0, 8'h22);
        port_edge();
        chk("R8 full txe_n", {7'd0, txe_n}, 8'd1);
        drive(1'b1, 1'b1, 1'b0, 8'h33);
        port_edge();
        chk("R8 still full", {7'd0, txe_n}, 8'd1);
        tx_ready = 1'b1;
        drive(1'b1, 1'b1, 1'b1, 8'h00);
        port_edge();
        chk("R8 room again", {7'd0, txe_n}, 8'd0);
        chk("R8 sink count", 8'(sink_n), 8'd4);
        chk("R8 sink2", sink[2], 8'h11);
        chk("R8 sink3", sink[3], 8'h22);

        summary();
    end
endmodule